// File: doc/BRIEF.md
# Reset-Configured Synchronous FIFO Controller

This block is a single-clock first-in first-out buffer for 9-bit words with a parameterised depth. Writing and reading use active-low enables, and four active-low status outputs report the fill level: empty, full, almost-empty and almost-full. A shared input pin is sampled while reset is held low, and that sample fixes the operating mode until the next reset. In one mode the pin is a second write enable, so several buffers can be cascaded for depth expansion. In the other mode the pin is a load strobe. Each strobe writes the next half of the two threshold registers that drive the almost-empty and almost-full outputs.

A read needs both read enables low. The word then moves from storage into an output register. A separate output-enable input decides whether that register is presented on the data output. When the output is disabled, a drive-qualifier output goes low and the data output reads zero. The tri-state pad itself sits outside the block.

Top module: `fifoTop`

## Requirements
- R1: On every clock edge with `rstN` low, the level on `wen2LdN` is captured as the mode. High selects dual-write-enable mode. Low selects threshold-load mode. The mode then holds until the next reset.
- R2: In dual-write-enable mode, a word is stored only on an edge where `wen1N` is low and `wen2LdN` is high. `wen1N` low with `wen2LdN` low stores nothing and changes no threshold.
- R3: In threshold-load mode, `wen1N` low with `wen2LdN` high stores a word. `wen1N` low with `wen2LdN` low stores no word. Instead it copies `wrData[7:0]` into the next threshold half, in the repeating order: empty-threshold bits 7:0, empty-threshold bits 15:8, full-threshold bits 7:0, full-threshold bits 15:8.
- R4: An edge with both `ren1N` and `ren2N` low loads the oldest stored word into the output register. With either one high, the output register keeps its value. Words leave in the order they were stored.
- R5: Write requests are ignored while the buffer holds DEPTH words. Read requests are ignored while it holds none.
- R6: While `rstN` is low, `ffN` and `pafN` are high and `efN` and `paeN` are low. A reset edge empties the buffer, clears the output register to zero and restores both thresholds to their default values of 7.
- R7: With `oeN` low, `dataOutEn` is 1 and `dataOut` shows the output register. With `oeN` high, `dataOutEn` is 0 and `dataOut` is zero.
- R8: Outside reset, with N the number of stored words:
  - `efN` is low exactly when N = 0.
  - `ffN` is low exactly when N = DEPTH.
  - `paeN` is low exactly when N ≤ the empty threshold.
  - `pafN` is low exactly when DEPTH − N ≤ the full threshold.
  
  Each flag reflects the edge just taken.
- R9: A write and a read accepted on the same edge leave N unchanged. When the buffer is full and both kinds of request arrive, the read is accepted and the write is dropped, so `ffN` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for storage, pointers and flags |
| rstN | input | 1 | Synchronous active-low reset; also the mode sampling window |
| wrData | input | 9 | Word to store; low 8 bits also feed threshold loads |
| wen1N | input | 1 | Primary write enable, active low |
| wen2LdN | input | 1 | Mode select during reset; afterwards a second write enable or a threshold-load strobe |
| ren1N | input | 1 | First read enable, active low |
| ren2N | input | 1 | Second read enable, active low |
| oeN | input | 1 | Output enable, active low |
| dataOut | output | 9 | Output register when enabled, zero otherwise |
| dataOutEn | output | 1 | High when the data output is driven |
| efN | output | 1 | Empty flag, active low |
| ffN | output | 1 | Full flag, active low |
| paeN | output | 1 | Almost-empty flag, active low |
| pafN | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the block with DEPTH set to 16. At that depth, short runs of writes hit the full boundary again and again, so the ignored writes and the read-at-full case come up often. The default thresholds of 7 sit near the middle of 16, so both partial flags switch in normal traffic. Random threshold loads then move the switching points, including values larger than the depth, which keep a flag asserted. Data width and threshold half width stay at their defaults of 9 and 8.

// File: rtl/fifoPkg.sv
package fifoPkg;
  // strobes from the control section to the storage section
  typedef struct packed {
    logic clr;
    logic wrEn;
    logic rdEn;
  } fifoStrobe_t;
endpackage

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int HALF_W        = 8,
  parameter int DEF_EMPTY_OFF = 7,
  parameter int DEF_FULL_OFF  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wen1N,
  input  logic              wen2LdN,
  input  logic              ren1N,
  input  logic              ren2N,
  input  logic [HALF_W-1:0] ldData,
  output fifoStrobe_t       strobe,
  output logic              efN,
  output logic              ffN,
  output logic              paeN,
  output logic              pafN
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFF_W = 2 * HALF_W;
  localparam int CMP_W = ((OFF_W > CNT_W) ? OFF_W : CNT_W) + 1;

  logic             modeDual;
  logic [CNT_W-1:0] count;
  logic [OFF_W-1:0] emptyOff;
  logic [OFF_W-1:0] fullOff;
  logic [1:0]       loadIdx;
  logic             wrReq, rdReq, ldReq, wrAcc, rdAcc, isEmpty, isFull;
  logic [CMP_W-1:0] freeSlots;

  always_comb begin
    isEmpty = (count == '0);
    isFull  = (count == CNT_W'(DEPTH));
    wrReq   = !wen1N && wen2LdN;
    rdReq   = !ren1N && !ren2N;
    ldReq   = !modeDual && !wen1N && !wen2LdN;
    wrAcc   = rstN && wrReq && !isFull;
    rdAcc   = rstN && rdReq && !isEmpty;
    strobe  = '{clr: !rstN, wrEn: wrAcc, rdEn: rdAcc};
  end

  // mode is sampled on every edge of the reset window
  always_ff @(posedge clk) begin
    if (!rstN) modeDual <= wen2LdN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({wrAcc, rdAcc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // threshold halves are written in a fixed rotating order
  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyOff <= OFF_W'(DEF_EMPTY_OFF);
      fullOff  <= OFF_W'(DEF_FULL_OFF);
      loadIdx  <= '0;
    end else if (ldReq) begin
      unique case (loadIdx)
        2'd0: emptyOff[HALF_W-1:0]     <= ldData;
        2'd1: emptyOff[OFF_W-1:HALF_W] <= ldData;
        2'd2: fullOff[HALF_W-1:0]      <= ldData;
        default: fullOff[OFF_W-1:HALF_W] <= ldData;
      endcase
      loadIdx <= loadIdx + 1'b1;
    end
  end

  always_comb begin
    freeSlots = CMP_W'(DEPTH) - CMP_W'(count);
    if (!rstN) begin
      efN  = 1'b0;
      ffN  = 1'b1;
      paeN = 1'b0;
      pafN = 1'b1;
    end else begin
      efN  = !isEmpty;
      ffN  = !isFull;
      paeN = !(CMP_W'(count) <= CMP_W'(emptyOff));
      pafN = !(freeSlots <= CMP_W'(fullOff));
    end
  end
endmodule

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import fifoPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic [DATA_W-1:0] outReg
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.clr) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      outReg <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= nextPtr(wrPtr);
      if (strobe.rdEn) begin
        rdPtr  <= nextPtr(rdPtr);
        outReg <= mem[rdPtr];
      end
    end
  end

  always_comb begin
    dataOutEn = !oeN;
    dataOut   = oeN ? '0 : outReg;
  end
endmodule

// File: rtl/fifoTop.sv
module fifoTop
  import fifoPkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int DATA_W        = 9,
  parameter int HALF_W        = 8,
  parameter int DEF_EMPTY_OFF = 7,
  parameter int DEF_FULL_OFF  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wen1N,
  input  logic              wen2LdN,
  input  logic              ren1N,
  input  logic              ren2N,
  input  logic              oeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              efN,
  output logic              ffN,
  output logic              paeN,
  output logic              pafN
);
  fifoStrobe_t       strobe;
  logic [DATA_W-1:0] outReg;

  fifoCtrl #(
    .DEPTH(DEPTH), .HALF_W(HALF_W),
    .DEF_EMPTY_OFF(DEF_EMPTY_OFF), .DEF_FULL_OFF(DEF_FULL_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wen1N(wen1N), .wen2LdN(wen2LdN),
    .ren1N(ren1N), .ren2N(ren2N), .ldData(wrData[HALF_W-1:0]),
    .strobe(strobe), .efN(efN), .ffN(ffN), .paeN(paeN), .pafN(pafN)
  );

  fifoDatapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .strobe(strobe), .wrData(wrData), .oeN(oeN),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .outReg(outReg)
  );
endmodule

// File: rtl/fifoChecker.sv
module fifoChecker #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              wen1N,
  input logic              wen2LdN,
  input logic              ren1N,
  input logic              ren2N,
  input logic              efN,
  input logic              ffN,
  input logic              paeN,
  input logic              pafN,
  input logic [DATA_W-1:0] outReg
);
  assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ffN && (ren1N || ren2N)) |=> !ffN);

  assert_empty_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!efN && (wen1N || !wen2LdN)) |=> !efN);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ren1N || ren2N) |=> $stable(outReg));

  assert_read_at_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ffN && !ren1N && !ren2N) |=> ffN);

  assert_empty_nests_R8: assert property (@(posedge clk) disable iff (!rstN)
    !efN |-> !paeN);

  assert_full_nests_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ffN |-> (!pafN && efN));

  assert_reset_levels_R6: assert property (@(posedge clk)
    !rstN |-> (!efN && ffN && !paeN && pafN));
endmodule

bind fifoTop fifoChecker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .wen1N(wen1N), .wen2LdN(wen2LdN),
  .ren1N(ren1N), .ren2N(ren2N), .efN(efN), .ffN(ffN),
  .paeN(paeN), .pafN(pafN), .outReg(outReg)
);

// File: tb/tb_fifoTop.sv
`timescale 1ns/1ps
module tb_fifoTop;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 9;
  localparam int DEF_O  = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, wen1N = 1'b1, wen2LdN = 1'b1, ren1N = 1'b1, ren2N = 1'b1, oeN = 1'b1;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataOutEn, efN, ffN, paeN, pafN;

  fifoTop #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wen1N(wen1N), .wen2LdN(wen2LdN),
    .ren1N(ren1N), .ren2N(ren2N), .oeN(oeN), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .efN(efN), .ffN(ffN), .paeN(paeN), .pafN(pafN)
  );

  int q[$];
  bit mDual;
  int mEmptyOff = DEF_O, mFullOff = DEF_O, mIdx = 0, mOut = 0;
  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int setHalf(int v, int half, int b);
    return half ? ((v & 'hFF) | (b << 8)) : ((v & 'hFF00) | b);
  endfunction

  task automatic checkAll();
    int n = q.size();
    if (!rstN) begin
      chk("R6 efN", efN, 0);  chk("R6 ffN", ffN, 1);
      chk("R6 paeN", paeN, 0); chk("R6 pafN", pafN, 1);
    end else begin
      chk("R8 efN", efN, n != 0);
      chk("R8 ffN", ffN, n != DEPTH);
      chk("R8 paeN", paeN, !(n <= mEmptyOff));
      chk("R8 pafN", pafN, !((DEPTH - n) <= mFullOff));
    end
    chk("R7 dataOutEn", dataOutEn, !oeN);
    chk("R4 R7 dataOut", dataOut, oeN ? 0 : mOut);
  endtask

  task automatic step();
    int  n = q.size();
    bit  ld   = rstN && !mDual && !wen1N && !wen2LdN;
    bit  wAcc = rstN && !wen1N && wen2LdN && n < DEPTH;
    bit  rAcc = rstN && !ren1N && !ren2N && n > 0;
    int  d    = int'(wrData);
    @(posedge clk);
    if (!rstN) begin
      mDual = wen2LdN; q.delete(); mOut = 0;
      mEmptyOff = DEF_O; mFullOff = DEF_O; mIdx = 0;
    end else begin
      if (rAcc) mOut = q.pop_front();
      if (wAcc) q.push_back(d);
      if (ld) begin
        if (mIdx < 2) mEmptyOff = setHalf(mEmptyOff, mIdx, d & 'hFF);
        else          mFullOff  = setHalf(mFullOff, mIdx - 2, d & 'hFF);
        mIdx = (mIdx + 1) % 4;
      end
    end
    @(negedge clk);
    checkAll();
  endtask

  task automatic idle();
    wen1N = 1; wen2LdN = 1; ren1N = 1; ren2N = 1;
  endtask

  task automatic doReset(bit modeBit);
    idle(); rstN = 0; wen2LdN = modeBit;
    repeat (2) step();
    rstN = 1; wen2LdN = 1;
  endtask

  task automatic writeN(int k);
    for (int i = 0; i < k; i++) begin
      wen1N = 0; wen2LdN = 1; wrData = DATA_W'($urandom); step();
    end
    idle();
  endtask

  task automatic readN(int k);
    for (int i = 0; i < k; i++) begin
      ren1N = 0; ren2N = 0; step();
    end
    idle();
  endtask

  task automatic loadHalf(int b);
    wen1N = 0; wen2LdN = 0; wrData = DATA_W'(b); step(); idle();
  endtask

  task automatic randomRun(int cycles, int ldPct);
    for (int i = 0; i < cycles; i++) begin
      wen1N   = ($urandom % 100) < 45;
      wen2LdN = ($urandom % 100) >= ldPct;
      ren1N   = ($urandom % 100) < 30;
      ren2N   = ($urandom % 100) < 30;
      oeN     = ($urandom % 100) < 20;
      wrData  = DATA_W'($urandom);
      step();
    end
    idle(); oeN = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    @(negedge clk);
    // threshold-load mode
    doReset(1'b0);
    oeN = 0; step();
    chk("R6 output register cleared", dataOut, 0);
    chk("R6 empty after reset", efN, 0);
    // R1 R3: a load strobe moves the empty threshold, not the buffer
    writeN(3);
    chk("R3 paeN at default threshold", paeN, 0);
    loadHalf(1);
    chk("R1 R3 empty threshold low half loaded", paeN, 1);
    loadHalf(0); loadHalf(2); loadHalf(0);
    loadHalf(3);
    chk("R3 sequence wraps to empty low half", paeN, 0);
    readN(3);
    chk("R3 loads stored no words", efN, 0);
    // R5 R9: fill, overfill, read at full, drain
    writeN(DEPTH + 3);
    chk("R5 full after overfill", ffN, 0);
    wen1N = 0; wen2LdN = 1; ren1N = 0; ren2N = 0; wrData = 9'h1AB; step(); idle();
    chk("R9 read accepted at full, write dropped", ffN, 1);
    wen1N = 0; ren1N = 0; ren2N = 0; wrData = 9'h055; step(); idle();
    chk("R9 simultaneous keeps count", ffN, 1);
    ren1N = 0; ren2N = 1; step(); idle();
    chk("R4 one enable high holds data", ffN, 1);
    readN(DEPTH + 2);
    chk("R5 empty after overdrain", efN, 0);
    randomRun(800, 8);
    // dual-write-enable mode
    doReset(1'b1);
    oeN = 0; step();
    writeN(3);
    loadHalf(1);
    chk("R1 R2 strobe ignored in dual mode", paeN, 0);
    readN(3);
    chk("R2 nothing stored without second enable", efN, 0);
    writeN(DEPTH);
    chk("R5 full in dual mode", ffN, 0);
    readN(DEPTH);
    randomRun(800, 40);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule